// File: doc/BRIEF.md
# Emergency Throttle and Rollback Controller

This block sits between three neighbours: a supply-margin sensor that reports when a voltage emergency has actually happened, a signature predictor that reports when the current activity history matches a learned emergency pattern, and a checkpoint-recovery engine that restores machine state. A predictor match starts throttling at once. For a fixed window the core then runs at half rate, with its clock enable dropped on every other cycle. The predictor is expected to give about 16 cycles of warning, and the window is sized to cover that lead time. A match that arrives while a window is running restarts the window.

A margin violation starts the recovery path. The controller sends a one-cycle rollback request to the recovery engine. In the same cycle it presents a frozen copy of the event-history snapshot to the predictor, together with an insert strobe, so that the predictor learns the new signature. It then holds the pipeline stalled for the fixed rollback penalty. The sensor never starts throttling, so the latency of the sensor has no effect on correctness. A violation that occurs while throttling is active still forces a rollback. In that case the rollback takes precedence and the throttle window is dropped.

Three event counters are provided for observation: cycles spent throttled, rollbacks started, and predictor matches accepted.

Top module: `emer_throttle_ctrl`

## Requirements
- R1: After synchronous reset the clock enable is 1, and throttle_active_o, stall_o, rb_req_o and pred_insert_o are 0. pred_sig_o and all three counters are 0.
- R2: A predictor hit sampled while the block is neither stalled nor seeing a violation puts it into throttling from the next cycle. The clock enable is 0 in the first throttled cycle and then alternates 1, 0, 1 and so on, giving half rate.
- R3: A hit sampled during an active throttle window reloads the window to its full length WIN. It also restarts the alternation, so the next cycle is a gated cycle.
- R4: With no further hits, throttling lasts exactly WIN cycles. The block then returns to clk_en_o = 1 with throttle_active_o = 0.
- R5: A violation sampled while the block is not stalled produces a one-cycle pulse on rb_req_o and on pred_insert_o in the next cycle. From that cycle on, pred_sig_o holds the history snapshot as it was sampled together with the violation.
- R6: A rollback keeps stall_o = 1 and clk_en_o = 0 for exactly PENALTY cycles when rb_done_i has been seen by the last of those cycles. When rb_done_i comes later, the stall lasts through the cycle in which rb_done_i is sampled high.
- R7: A violation sampled during throttling cancels the window and starts a rollback. Throttling does not resume after the rollback ends.
- R8: When a hit and a violation are sampled in the same cycle, the violation wins: the block starts a rollback, and the hit neither starts throttling nor increments the hit counter.
- R9: While the block is stalled, hits and violations are ignored. The stall length is unchanged, pred_sig_o is unchanged and no counter moves.
- R10: thr_cnt_o counts the cycles spent with throttle_active_o = 1. rb_cnt_o counts the rollbacks started. hit_cnt_o counts the hits accepted.
- R11: pred_sig_o keeps its captured value until the next accepted violation, whatever happens on hist_snap_i in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sensor_viol_i | input | 1 | Margin violation detected by the sensor |
| pred_hit_i | input | 1 | Predictor signature match |
| hist_snap_i | input | HIST_W | Current event-history contents |
| rb_done_i | input | 1 | Recovery engine has finished restoring state |
| rb_req_o | output | 1 | One-cycle rollback request |
| pred_insert_o | output | 1 | One-cycle strobe to insert pred_sig_o as a new signature |
| pred_sig_o | output | HIST_W | Frozen history snapshot for the predictor |
| clk_en_o | output | 1 | Pipeline clock enable |
| throttle_active_o | output | 1 | Throttle window running |
| stall_o | output | 1 | Rollback stall in progress |
| thr_cnt_o | output | CNT_W | Throttled-cycle count |
| rb_cnt_o | output | CNT_W | Rollback count |
| hit_cnt_o | output | CNT_W | Accepted-hit count |

## Verification
The hardest cases to reach are the boundaries between modes. These include a violation that arrives in the first cycle after a stall ends, a hit that lands on the last cycle of a window, and a completion signal that shows up only after the penalty has expired. The stimulus reaches the first by holding the violation input high across an entire rollback, so that it is sampled again on the very first free cycle. It reaches the others by timing hits and completion pulses against the known window and penalty lengths. Hits and violations are also sprinkled through stalls, and a hit is sent together with a violation, to show that the priority rules hold at the ports.

// File: rtl/emer_pkg.sv
package emer_pkg;

    typedef enum logic [1:0] {
        MODE_RUN = 2'd0,
        MODE_THR = 2'd1,
        MODE_RCV = 2'd2
    } mode_e;

    typedef struct packed {
        logic viol;
        logic hit;
    } accept_t;

    localparam int unsigned NUM_CNT = 3;
    localparam int unsigned CNT_THR = 0;
    localparam int unsigned CNT_RB  = 1;
    localparam int unsigned CNT_HIT = 2;

    function automatic accept_t accept_events(mode_e cur, logic viol, logic hit);
        accept_t a;
        a.viol = viol && (cur != MODE_RCV);
        a.hit  = hit && !viol && (cur != MODE_RCV);
        return a;
    endfunction

    function automatic mode_e next_mode(mode_e cur, accept_t acc,
                                        logic win_last, logic rcv_fin);
        if (acc.viol) return MODE_RCV;
        if (cur == MODE_RCV) return rcv_fin ? MODE_RUN : MODE_RCV;
        if (acc.hit) return MODE_THR;
        if (cur == MODE_THR && win_last) return MODE_RUN;
        return cur;
    endfunction

endpackage

// File: rtl/emer_thr_window.sv
module emer_thr_window #(
    parameter int unsigned WIN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic last,
    output logic phase
);
    localparam int unsigned WW = $clog2(WIN + 1);

    logic [WW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= WW'(WIN - 1);
            phase_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            phase_q <= ~phase_q;
        end
    end

    assign last  = (cnt_q == '0);
    assign phase = phase_q;
endmodule

// File: rtl/emer_rcv_timer.sv
module emer_rcv_timer #(
    parameter int unsigned PENALTY = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic done_i,
    output logic fin
);
    localparam int unsigned PW = $clog2(PENALTY + 1);

    logic [PW-1:0] cnt_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= PW'(PENALTY - 1);
            seen_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (done_i) seen_q <= 1'b1;
        end
    end

    assign fin = run && (cnt_q == '0) && (seen_q || done_i);
endmodule

// File: rtl/emer_ev_counter.sv
module emer_ev_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/emer_throttle_ctrl.sv
module emer_throttle_ctrl
    import emer_pkg::*;
#(
    parameter int unsigned HIST_ENTRIES = 4,
    parameter int unsigned ENTRY_W      = 8,
    parameter int unsigned WIN          = 32,
    parameter int unsigned PENALTY      = 100,
    parameter int unsigned CNT_W        = 16,
    localparam int unsigned HIST_W      = HIST_ENTRIES * ENTRY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sensor_viol_i,
    input  logic              pred_hit_i,
    input  logic [HIST_W-1:0] hist_snap_i,
    input  logic              rb_done_i,
    output logic              rb_req_o,
    output logic              pred_insert_o,
    output logic [HIST_W-1:0] pred_sig_o,
    output logic              clk_en_o,
    output logic              throttle_active_o,
    output logic              stall_o,
    output logic [CNT_W-1:0]  thr_cnt_o,
    output logic [CNT_W-1:0]  rb_cnt_o,
    output logic [CNT_W-1:0]  hit_cnt_o
);
    mode_e             mode_q;
    accept_t           acc;
    logic              win_last, win_phase, rcv_fin;
    logic              req_q;
    logic [HIST_W-1:0] sig_q;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];

    assign acc = accept_events(mode_q, sensor_viol_i, pred_hit_i);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= next_mode(mode_q, acc, win_last, rcv_fin);
    end

    emer_thr_window #(.WIN(WIN)) win_i (
        .clk   (clk),
        .rst   (rst),
        .load  (acc.hit),
        .run   (mode_q == MODE_THR),
        .last  (win_last),
        .phase (win_phase)
    );

    emer_rcv_timer #(.PENALTY(PENALTY)) rcv_i (
        .clk    (clk),
        .rst    (rst),
        .load   (acc.viol),
        .run    (mode_q == MODE_RCV),
        .done_i (rb_done_i),
        .fin    (rcv_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            sig_q <= '0;
        end else begin
            req_q <= acc.viol;
            if (acc.viol) sig_q <= hist_snap_i;
        end
    end

    assign cnt_inc[CNT_THR] = (mode_q == MODE_THR);
    assign cnt_inc[CNT_RB]  = acc.viol;
    assign cnt_inc[CNT_HIT] = acc.hit;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        emer_ev_counter #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_inc[g]),
            .value (cnt_val[g])
        );
    end

    always_comb begin
        unique case (mode_q)
            MODE_THR: clk_en_o = win_phase;
            MODE_RCV: clk_en_o = 1'b0;
            default:  clk_en_o = 1'b1;
        endcase
    end

    assign throttle_active_o = (mode_q == MODE_THR);
    assign stall_o           = (mode_q == MODE_RCV);
    assign rb_req_o          = req_q;
    assign pred_insert_o     = req_q;
    assign pred_sig_o        = sig_q;
    assign thr_cnt_o         = cnt_val[CNT_THR];
    assign rb_cnt_o          = cnt_val[CNT_RB];
    assign hit_cnt_o         = cnt_val[CNT_HIT];
endmodule

// File: rtl/emer_throttle_chk.sv
module emer_throttle_chk #(
    parameter int unsigned PENALTY = 100,
    parameter int unsigned CNT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sensor_viol_i,
    input logic             pred_hit_i,
    input logic             rb_req_o,
    input logic             clk_en_o,
    input logic             throttle_active_o,
    input logic             stall_o,
    input logic [CNT_W-1:0] hit_cnt_o
);
    logic [15:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst)          stall_run <= '0;
        else if (stall_o) stall_run <= stall_run + 1'b1;
        else              stall_run <= '0;
    end

    assert_req_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rb_req_o |=> !rb_req_o);

    assert_req_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
        rb_req_o |-> stall_o);

    assert_stall_gated_R6: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !clk_en_o);

    assert_min_penalty_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && stall_run != '0) |-> (32'(stall_run) >= PENALTY));

    assert_half_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (throttle_active_o && !clk_en_o && !pred_hit_i && !sensor_viol_i) |=> clk_en_o);

    assert_hit_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (pred_hit_i && !sensor_viol_i && !stall_o) |=> (throttle_active_o && !clk_en_o));

    assert_viol_rollback_R7: assert property (@(posedge clk) disable iff (rst)
        (sensor_viol_i && !stall_o) |=> (stall_o && rb_req_o && !throttle_active_o));

    assert_stall_ignores_hit_R9: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(hit_cnt_o));
endmodule

bind emer_throttle_ctrl emer_throttle_chk #(.PENALTY(PENALTY), .CNT_W(CNT_W)) chk_i (
    .clk               (clk),
    .rst               (rst),
    .sensor_viol_i     (sensor_viol_i),
    .pred_hit_i        (pred_hit_i),
    .rb_req_o          (rb_req_o),
    .clk_en_o          (clk_en_o),
    .throttle_active_o (throttle_active_o),
    .stall_o           (stall_o),
    .hit_cnt_o         (hit_cnt_o)
);

// File: tb/emer_throttle_ctrl_tb_top.sv
module emer_throttle_ctrl_tb_top;
    localparam int WIN     = 32;
    localparam int PENALTY = 100;
    localparam int CNT_W   = 16;
    localparam int HIST_W  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              viol = 1'b0, hit = 1'b0, done = 1'b0;
    logic [HIST_W-1:0] snap = '0;
    logic              rb_req, ins, clk_en, thr_act, stall;
    logic [HIST_W-1:0] sig;
    logic [CNT_W-1:0]  thr_cnt, rb_cnt, hit_cnt;

    int checks = 0;
    int fails  = 0;
    int cyc_no = 0;

    // reference state: 0 run, 1 throttle, 2 recovery
    int m_mode, m_win, m_phase, m_pen, m_seen, m_req;
    int m_thr, m_rb, m_hit;
    logic [HIST_W-1:0] m_sig;

    always #10 clk = ~clk;

    emer_throttle_ctrl dut_i (
        .clk (clk), .rst (rst),
        .sensor_viol_i (viol), .pred_hit_i (hit),
        .hist_snap_i (snap), .rb_done_i (done),
        .rb_req_o (rb_req), .pred_insert_o (ins), .pred_sig_o (sig),
        .clk_en_o (clk_en), .throttle_active_o (thr_act), .stall_o (stall),
        .thr_cnt_o (thr_cnt), .rb_cnt_o (rb_cnt), .hit_cnt_o (hit_cnt)
    );

    always @(posedge clk) begin
        int av, ah;
        if (rst) begin
            m_mode = 0; m_win = 0; m_phase = 0; m_pen = 0; m_seen = 0; m_req = 0;
            m_thr = 0; m_rb = 0; m_hit = 0; m_sig = '0;
        end else begin
            av = (viol && m_mode != 2) ? 1 : 0;
            ah = (hit && !viol && m_mode != 2) ? 1 : 0;
            m_req = av;
            if (av != 0) m_sig = snap;
            if (m_mode == 1) m_thr++;
            if (av != 0) m_rb++;
            if (ah != 0) m_hit++;
            if (av != 0) begin
                m_mode = 2; m_pen = PENALTY - 1; m_seen = 0;
            end else if (m_mode == 2) begin
                if (m_pen == 0 && (m_seen != 0 || done)) m_mode = 0;
                else begin
                    if (m_pen > 0) m_pen--;
                    if (done) m_seen = 1;
                end
            end else if (ah != 0) begin
                m_mode = 1; m_win = WIN - 1; m_phase = 0;
            end else if (m_mode == 1) begin
                if (m_win == 0) m_mode = 0;
                else begin
                    m_win--; m_phase = 1 - m_phase;
                end
            end
        end
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc_no, act, exp);
        end
    endtask

    task automatic compare_all();
        int exp_en;
        exp_en = (m_mode == 0) ? 1 : ((m_mode == 1) ? m_phase : 0);
        chk("R2_R4_R6", "clk_en", clk_en, exp_en);
        chk("R3_R7", "throttle_active", thr_act, (m_mode == 1) ? 1 : 0);
        chk("R6_R9", "stall", stall, (m_mode == 2) ? 1 : 0);
        chk("R5_R8", "rb_req", rb_req, m_req);
        chk("R5", "pred_insert", ins, m_req);
        chk("R5_R11", "pred_sig", sig, m_sig);
        chk("R10", "thr_cnt", thr_cnt, m_thr & 16'hFFFF);
        chk("R10_R8", "rb_cnt", rb_cnt, m_rb & 16'hFFFF);
        chk("R10_R9", "hit_cnt", hit_cnt, m_hit & 16'hFFFF);
    endtask

    task automatic cyc(logic v, logic h, logic d, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_no++;
            compare_all();
            viol = v; hit = h; done = d;
            snap = 32'hA55A_0000 ^ (cyc_no * 32'h0101_0103);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; viol = 1'b0; hit = 1'b0; done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk("R1", "reset clk_en", clk_en, 1);
        chk("R1", "reset stall", stall, 0);
        chk("R1", "reset throttle", thr_act, 0);
        chk("R1", "reset rb_req", rb_req, 0);
        chk("R1", "reset insert", ins, 0);
        chk("R1", "reset sig", sig, 0);
        chk("R1", "reset counters", {thr_cnt, rb_cnt, hit_cnt}, 0);
    endtask

    initial begin
        do_reset();
        cyc(0, 0, 0, 5);
        // R2 R4: single hit, full window then back to run
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, WIN + 6);
        // R3: restart in mid window and on the last window cycle
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 9);
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, WIN - 1);
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, WIN + 4);
        // R5 R6: violation from run, early done
        cyc(1, 0, 0, 1);
        cyc(0, 0, 0, 19);
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, PENALTY);
        // R6 R9: late done, hits and violations inside the stall
        cyc(1, 0, 0, 1);
        for (int k = 0; k < 12; k++) begin
            cyc(k[0], ~k[0], 0, 1);
            cyc(0, 0, 0, 9);
        end
        cyc(0, 0, 0, 20);
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, 6);
        // R7: violation during throttle
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 6);
        cyc(1, 0, 1, 1);
        cyc(0, 0, 1, PENALTY + 5);
        // R8: hit and violation together
        cyc(1, 1, 0, 1);
        cyc(0, 0, 1, PENALTY + 5);
        // R11: violation held across a whole stall, re-sampled on first free cycle
        cyc(1, 0, 1, 2 * PENALTY + 10);
        cyc(0, 0, 0, PENALTY + 5);
        // R2: throttle again, then reset mid-window (R1)
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 7);
        do_reset();
        cyc(0, 0, 0, 4);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule